// File: doc/BRIEF.md
# MSI pending vector scanner

This block services one group of a message-signalled interrupt termination bank. Each group has a summary register and a set of index registers. Bit k of the summary register flags index register k as holding pending bits. Every index register clears itself when it is read. On a trigger, the scanner reads the summary and keeps a local copy of it. It then visits the flagged index registers from the lowest bit upward and reads each one exactly once. For every set bit in a value it has read, it emits one vector number, lowest bit first.

When the local summary copy runs out, the scanner reads the summary again. Bits that arrived during the pass are serviced in a further pass. The scan finishes only when a summary read returns zero, and a one-cycle done pulse marks that moment.

Several vector numbers alias to one logical interrupt, one alias per CPU. The scanner therefore reduces each vector to its CPU-0 alias before emitting it. Vectors leave through a valid/ready output. The register read port has a fixed latency: read data is taken in the cycle after the read strobe and is held by the bank until the next read.

Top module: `msi_pend_scan`

## Requirements
- R1: With no trigger, no register read is issued. A `start` or `grp_irq` pulse seen in the idle state starts a scan. The first read of every scan is a summary read (`rd_sum`=1), issued in the cycle after the trigger.
- R2: Within one pass, index registers are read in strictly ascending index order, which is lowest set summary bit first.
- R3: The bits of one index value are emitted lowest set bit first. Each set bit gives exactly one vector.
- R4: The raw vector for index k, bit b and group g is ((k*16)+b)*16+g, formed as the concatenation {k[2:0], b[3:0], g[3:0]} for the default sizes.
- R5: The emitted vector is the raw vector minus (raw mod NUM_CPUS). NUM_CPUS is a power of two from 1 to 8, so the low log2(NUM_CPUS) bits are zero.
- R6: Between two summary reads, an index register is read at most once, and only if its bit was set in the most recent summary value. Bit k of the summary data (rd_data[k]) flags index register k.
- R7: After the last flagged index of a pass, the summary is read again. Bits that arrived during the pass are then scanned, so the number of summary reads in a scan equals the number of non-empty passes plus one.
- R8: `done` is high for exactly one cycle, following a summary read that returned zero. No vector is pending at that point, and the scanner returns to idle.
- R9: While `vec_valid` is high and `vec_ready` is low, `vec_num` stays stable and no register read is issued.
- R10: An index register that is flagged in the summary but reads as zero produces no vector, and the scan moves on to the next flagged index.
- R11: After reset, `vec_valid`, `rd_en` and `done` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| grp_id | input | 4 | Group number of the serviced group, held static |
| start | input | 1 | Software-style scan trigger pulse |
| grp_irq | input | 1 | Group interrupt line; starts a scan when idle |
| rd_en | output | 1 | Register read strobe |
| rd_sum | output | 1 | 1 selects the summary register, 0 an index register |
| rd_idx | output | 3 | Index register number for index reads |
| rd_data | input | 16 | Read data, valid the cycle after `rd_en` |
| vec_valid | output | 1 | Vector available |
| vec_ready | input | 1 | Consumer accepts the vector |
| vec_num | output | 11 | Canonical vector number |
| done | output | 1 | One-cycle pulse when a summary read returns zero |

## Verification
The hardest situation to reach is a bit that arrives after its index register has already been read in the current pass. That bit must wait for the resample and appear in a later pass. The bench reaches it by writing new bits into index 0 of its bank model at the moment the first vector is accepted. At that moment index 0 has been read and a higher index is still pending. The bench then counts three summary reads, where a scan without the injected bits would need two. A second case is hard to produce from a consistent bank: a summary bit whose index register reads zero. The bench creates it with a one-shot phantom bit ORed into a single summary read.

// File: rtl/msi_scan_pkg.sv
package msi_scan_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SUM_RD,
    ST_SUM_WT,
    ST_IDX_RD,
    ST_IDX_WT,
    ST_EMIT
  } scan_st_e;

endpackage

// File: rtl/msi_scan_ctrl.sv
module msi_scan_ctrl
  import msi_scan_pkg::*;
#(
  parameter int NUM_IDX      = 8,
  parameter int BITS_PER_IDX = 16,
  localparam int IDX_W       = $clog2(NUM_IDX)
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    start,
  input  logic                    grp_irq,
  output logic                    rd_en,
  output logic                    rd_sum,
  output logic [IDX_W-1:0]        rd_idx,
  input  logic [BITS_PER_IDX-1:0] rd_data,
  output logic                    emit,
  input  logic                    take,
  output logic [IDX_W-1:0]        cur_idx,
  output logic [BITS_PER_IDX-1:0] cur_bits,
  output logic                    done
);

  scan_st_e                state;
  logic [NUM_IDX-1:0]      sum_copy;
  logic [NUM_IDX-1:0]      sum_left;
  logic [BITS_PER_IDX-1:0] bits_left;
  logic [NUM_IDX-1:0]      sum_rd_val;

  // position of the lowest set flag in a summary copy
  function automatic logic [IDX_W-1:0] low_flag(input logic [NUM_IDX-1:0] v);
    low_flag = '0;
    for (int i = NUM_IDX - 1; i >= 0; i--)
      if (v[i]) low_flag = IDX_W'(i);
  endfunction

  assign sum_rd_val = rd_data[NUM_IDX-1:0];
  assign sum_left   = sum_copy & ~(NUM_IDX'(1) << cur_idx);
  assign bits_left  = cur_bits & (cur_bits - 1'b1);

  assign rd_en  = (state == ST_SUM_RD) || (state == ST_IDX_RD);
  assign rd_sum = (state == ST_SUM_RD);
  assign rd_idx = low_flag(sum_copy);
  assign emit   = (state == ST_EMIT);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state    <= ST_IDLE;
      sum_copy <= '0;
      cur_idx  <= '0;
      cur_bits <= '0;
      done     <= 1'b0;
    end else begin
      done <= 1'b0;
      case (state)
        ST_IDLE:   if (start || grp_irq) state <= ST_SUM_RD;
        ST_SUM_RD: state <= ST_SUM_WT;
        ST_SUM_WT: begin
          sum_copy <= sum_rd_val;
          if (sum_rd_val == '0) begin
            done  <= 1'b1;
            state <= ST_IDLE;
          end else begin
            state <= ST_IDX_RD;
          end
        end
        ST_IDX_RD: begin
          cur_idx <= low_flag(sum_copy);
          state   <= ST_IDX_WT;
        end
        ST_IDX_WT: begin
          cur_bits <= rd_data;
          sum_copy <= sum_left;
          if (rd_data != '0)      state <= ST_EMIT;
          else if (sum_left != '0) state <= ST_IDX_RD;
          else                    state <= ST_SUM_RD;
        end
        ST_EMIT: begin
          if (take) begin
            cur_bits <= bits_left;
            if (bits_left != '0)     state <= ST_EMIT;
            else if (sum_copy != '0) state <= ST_IDX_RD;
            else                     state <= ST_SUM_RD;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // R6: reads are separated by the wait for their data
  a_r6_read_spacing: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en |=> !rd_en);

  // R6: an index read targets a flag still present in the summary copy
  a_r6_flagged_only: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && !rd_sum) |-> sum_copy[rd_idx]);

  // R9: a stalled vector keeps its index and bit set
  a_r9_hold_state: assert property (@(posedge clk) disable iff (!rst_n)
    (emit && !take) |=> (emit && $stable(cur_idx) && $stable(cur_bits)));

endmodule

// File: rtl/msi_vec_form.sv
module msi_vec_form #(
  parameter int NUM_IDX      = 8,
  parameter int BITS_PER_IDX = 16,
  parameter int NUM_GRP      = 16,
  parameter int NUM_CPUS     = 8,
  localparam int IDX_W       = $clog2(NUM_IDX),
  localparam int BIT_W       = $clog2(BITS_PER_IDX),
  localparam int GRP_W       = $clog2(NUM_GRP),
  localparam int VEC_W       = IDX_W + BIT_W + GRP_W
) (
  input  logic [IDX_W-1:0]        idx,
  input  logic [BITS_PER_IDX-1:0] bits,
  input  logic [GRP_W-1:0]        grp,
  output logic [VEC_W-1:0]        vec
);

  localparam logic [VEC_W-1:0] CPU_MASK = VEC_W'(NUM_CPUS - 1);

  function automatic logic [BIT_W-1:0] low_bit(input logic [BITS_PER_IDX-1:0] v);
    low_bit = '0;
    for (int i = BITS_PER_IDX - 1; i >= 0; i--)
      if (v[i]) low_bit = BIT_W'(i);
  endfunction

  // ((idx * bits-per-index) + bit) * groups + group, all sizes powers of two
  function automatic logic [VEC_W-1:0] raw_vector(input logic [IDX_W-1:0] k,
                                                  input logic [BIT_W-1:0] b,
                                                  input logic [GRP_W-1:0] g);
    raw_vector = {k, b, g};
  endfunction

  logic [VEC_W-1:0] raw;
  assign raw = raw_vector(idx, low_bit(bits), grp);

  generate
    if (NUM_CPUS > 1) begin : g_fold
      assign vec = raw & ~CPU_MASK;
    end else begin : g_pass
      assign vec = raw;
    end
  endgenerate

endmodule

// File: rtl/msi_pend_scan.sv
module msi_pend_scan #(
  parameter int NUM_IDX      = 8,
  parameter int BITS_PER_IDX = 16,
  parameter int NUM_GRP      = 16,
  parameter int NUM_CPUS     = 8,
  localparam int IDX_W       = $clog2(NUM_IDX),
  localparam int BIT_W       = $clog2(BITS_PER_IDX),
  localparam int GRP_W       = $clog2(NUM_GRP),
  localparam int VEC_W       = IDX_W + BIT_W + GRP_W
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [GRP_W-1:0]        grp_id,
  input  logic                    start,
  input  logic                    grp_irq,
  output logic                    rd_en,
  output logic                    rd_sum,
  output logic [IDX_W-1:0]        rd_idx,
  input  logic [BITS_PER_IDX-1:0] rd_data,
  output logic                    vec_valid,
  input  logic                    vec_ready,
  output logic [VEC_W-1:0]        vec_num,
  output logic                    done
);

  logic [IDX_W-1:0]        cur_idx;
  logic [BITS_PER_IDX-1:0] cur_bits;

  msi_scan_ctrl #(
    .NUM_IDX      (NUM_IDX),
    .BITS_PER_IDX (BITS_PER_IDX)
  ) u_ctrl (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (start),
    .grp_irq  (grp_irq),
    .rd_en    (rd_en),
    .rd_sum   (rd_sum),
    .rd_idx   (rd_idx),
    .rd_data  (rd_data),
    .emit     (vec_valid),
    .take     (vec_ready),
    .cur_idx  (cur_idx),
    .cur_bits (cur_bits),
    .done     (done)
  );

  msi_vec_form #(
    .NUM_IDX      (NUM_IDX),
    .BITS_PER_IDX (BITS_PER_IDX),
    .NUM_GRP      (NUM_GRP),
    .NUM_CPUS     (NUM_CPUS)
  ) u_form (
    .idx  (cur_idx),
    .bits (cur_bits),
    .grp  (grp_id),
    .vec  (vec_num)
  );

  localparam logic [GRP_W-1:0] LOW_MASK = GRP_W'(NUM_CPUS - 1);

  // R9: the offered vector does not change while stalled
  a_r9_stable_vec: assert property (@(posedge clk) disable iff (!rst_n)
    (vec_valid && !vec_ready) |=> (vec_valid && $stable(vec_num)));

  // R9: no bank access while a vector is being offered
  a_r9_no_read: assert property (@(posedge clk) disable iff (!rst_n)
    vec_valid |-> !rd_en);

  // R8: done lasts a single cycle and never overlaps an offered vector
  a_r8_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  a_r8_done_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !vec_valid);

  // R4/R5: the group field carries the group with its CPU bits folded away
  a_r4_group_field: assert property (@(posedge clk) disable iff (!rst_n)
    vec_valid |-> (vec_num[GRP_W-1:0] == (grp_id & ~LOW_MASK)));

endmodule

// File: tb/test_msi_pend_scan.sv
`timescale 1ns/1ps
module test_msi_pend_scan;

  localparam int NCPU = 8;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  grp_id = 4'd0;
  logic        start = 1'b0;
  logic        grp_irq = 1'b0;
  logic        rd_en, rd_sum;
  logic [2:0]  rd_idx;
  logic [15:0] rd_data = 16'h0;
  logic        vec_valid;
  logic        vec_ready = 1'b0;
  logic [10:0] vec_num;
  logic        done;

  always #4 clk = ~clk;

  msi_pend_scan i_msi_pend_scan (
    .clk(clk), .rst_n(rst_n), .grp_id(grp_id), .start(start), .grp_irq(grp_irq),
    .rd_en(rd_en), .rd_sum(rd_sum), .rd_idx(rd_idx), .rd_data(rd_data),
    .vec_valid(vec_valid), .vec_ready(vec_ready), .vec_num(vec_num), .done(done)
  );

  int n_chk = 0;
  int n_bad = 0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int canon(input int k, input int b, input int g);
    int v;
    v = ((k * 16) + b) * 16 + g;
    return v - (v % NCPU);
  endfunction

  // stimulus-side settings, written only by the initial block
  logic [15:0] load_val [8];
  int          load_id = 0;
  int          trig_id = 0;
  bit          armed = 0;
  int          rdy_mode = 0;
  bit          ld_inject = 0;
  logic [15:0] ld_inj_val = 16'h0;
  logic [7:0]  ld_ghost = 8'h0;

  // bank model and reference, written only by the monitor
  logic [15:0] mem [8];
  int          expq[$];
  int          exp_n = 0, acc_cnt = 0, sum_reads = 0, done_cnt = 0;
  int          seen_load = 0, seen_trig = 0, cyc = 0;
  bit          first_rd = 0, inj_pend = 0, prev_stall = 0, prev_done = 0;
  logic [15:0] inj_val = 16'h0;
  logic [7:0]  ghost = 8'h0, flagged = 8'h0, seen = 8'h0;
  int          last_idx = -1;
  logic [10:0] prev_vec = '0;

  always @(negedge clk) begin
    bit rdy_n;
    cyc++;
    if (!rst_n) begin
      vec_ready = 1'b0;
      for (int k = 0; k < 8; k++) mem[k] = 16'h0;
    end else begin
      if (load_id != seen_load) begin
        seen_load = load_id;
        expq.delete();
        for (int k = 0; k < 8; k++) begin
          mem[k] = load_val[k];
          for (int b = 0; b < 16; b++)
            if (load_val[k][b]) expq.push_back(canon(k, b, int'(grp_id)));
        end
        if (ld_inject)
          for (int b = 0; b < 16; b++)
            if (ld_inj_val[b]) expq.push_back(canon(0, b, int'(grp_id)));
        inj_pend = ld_inject; inj_val = ld_inj_val; ghost = ld_ghost;
        exp_n = expq.size(); acc_cnt = 0; sum_reads = 0;
      end
      if (trig_id != seen_trig) begin
        seen_trig = trig_id;
        first_rd = 1;
      end
      rdy_n = (rdy_mode == 0) ? 1'b1 : ((cyc % 3) == 2);
      if (prev_stall)
        chk(vec_valid && vec_num == prev_vec, "R9 vector held while stalled", int'(vec_num), int'(prev_vec));
      if (vec_valid) chk(!rd_en, "R9 no read while offering", int'(rd_en), 0);
      if (prev_done) chk(!done, "R8 done lasts one cycle", int'(done), 0);
      if (done) begin
        chk(expq.size() == 0, "R8 done only when all vectors delivered", expq.size(), 0);
        done_cnt++;
      end
      if (rd_en) begin
        chk(armed, "R1 read without trigger", 1, 0);
        if (first_rd) chk(rd_sum, "R1 first read is summary", int'(rd_sum), 1);
        first_rd = 0;
        if (rd_sum) begin
          logic [7:0] s;
          s = ghost;
          for (int k = 0; k < 8; k++) if (mem[k] != 16'h0) s[k] = 1'b1;
          ghost = 8'h0;
          flagged = s; seen = 8'h0; last_idx = -1; sum_reads++;
          rd_data = {8'h0, s};
        end else begin
          int k;
          k = int'(rd_idx);
          chk(flagged[k] && !seen[k], "R6 index read once and only if flagged", k, -1);
          chk(k > last_idx, "R2 ascending index order", k, last_idx + 1);
          seen[k] = 1'b1; last_idx = k;
          rd_data = mem[k];
          mem[k] = 16'h0;
        end
      end
      if (vec_valid && rdy_n) begin
        if (expq.size() == 0) chk(0, "R3 unexpected vector", int'(vec_num), -1);
        else begin
          int e;
          e = expq.pop_front();
          chk(int'(vec_num) == e, "R3/R4/R5 vector order and value", int'(vec_num), e);
        end
        acc_cnt++;
        if (inj_pend) begin
          mem[0] = mem[0] | inj_val;
          inj_pend = 0;
        end
      end
      prev_stall = vec_valid && !rdy_n;
      prev_vec = vec_num;
      prev_done = done;
      vec_ready = rdy_n;
    end
  end

  // watchdog
  int wd = 0;
  always @(posedge clk) begin
    wd++;
    if (wd > 50000) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", wd, 50000);
      $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end

  task automatic scenario(input logic [3:0] g, input int mode, input bit use_irq,
                          input bit inj, input logic [15:0] iv, input logic [7:0] gh,
                          input int exp_sums, input string tag);
    int d0;
    @(negedge clk);
    grp_id = g; rdy_mode = mode; ld_inject = inj; ld_inj_val = iv; ld_ghost = gh;
    load_id++;
    @(negedge clk);
    @(negedge clk);
    d0 = done_cnt;
    armed = 1; trig_id++;
    if (use_irq) grp_irq = 1'b1; else start = 1'b1;
    @(negedge clk);
    start = 1'b0; grp_irq = 1'b0;
    while (done_cnt == d0) @(negedge clk);
    chk(acc_cnt == exp_n, {tag, " vector count"}, acc_cnt, exp_n);
    chk(sum_reads == exp_sums, {tag, " summary reads"}, sum_reads, exp_sums);
    repeat (2) @(negedge clk);
    armed = 0;
    repeat (4) @(negedge clk);
  endtask

  initial begin
    for (int k = 0; k < 8; k++) load_val[k] = 16'h0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R11 reset state
    chk(!vec_valid, "R11 vec_valid low", int'(vec_valid), 0);
    chk(!rd_en, "R11 rd_en low", int'(rd_en), 0);
    chk(!done, "R11 done low", int'(done), 0);
    // R1: idle without trigger, monitor flags any read
    repeat (6) @(negedge clk);

    // R8: empty bank, single summary read then done
    scenario(4'd5, 0, 0, 0, 16'h0, 8'h0, 1, "R8 empty scan");

    // R2/R3/R4/R5 basic pattern
    for (int k = 0; k < 8; k++) load_val[k] = 16'h0;
    load_val[1] = 16'h8001; load_val[6] = 16'h0012;
    scenario(4'd13, 0, 0, 0, 16'h0, 8'h0, 2, "R4 basic");

    // R9 stalls with two indices
    for (int k = 0; k < 8; k++) load_val[k] = 16'h0;
    load_val[3] = 16'h00F0; load_val[7] = 16'hC000;
    scenario(4'd7, 1, 0, 0, 16'h0, 8'h0, 2, "R9 stalled");

    // R7 resample: bits land in index 0 after it was read, irq trigger
    for (int k = 0; k < 8; k++) load_val[k] = 16'h0;
    load_val[0] = 16'h0003; load_val[4] = 16'h0100;
    scenario(4'd9, 0, 1, 1, 16'h0400, 8'h0, 3, "R7 resample");

    // R10 flagged index reading zero
    for (int k = 0; k < 8; k++) load_val[k] = 16'h0;
    load_val[5] = 16'h0001;
    scenario(4'd2, 0, 0, 0, 16'h0, 8'h04, 2, "R10 phantom flag");

    // R3 full index register, stalled, group 2
    for (int k = 0; k < 8; k++) load_val[k] = 16'h0;
    load_val[7] = 16'hFFFF; load_val[2] = 16'h0200;
    scenario(4'd2, 1, 1, 0, 16'h0, 8'h0, 2, "R3 full index");

    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

endmodule